// File: doc/BRIEF.md
# Tone and Melody Generator

This block makes PCM-coded call-progress tones and a short melody. Four tone engines each hold an 11-bit phase accumulator, an increment and a frame-count duration. Seven tone outputs each point at one of the four engines, so up to seven outputs can carry tones while only four distinct frequency and duration settings exist. A separate melody sequencer steps through a table of up to 32 entries. Each entry holds its own increment and duration.

Every engine advances once per frame strobe, which is nominally 8 kHz. The output frequency is the increment times 8000/2048 Hz, which gives a step of about 3.9 Hz. Increments are capped at 1008, which is about 3938 Hz. A time-slot requester asks for the sample of one source (a tone output or the melody). One cycle later the block returns an 8-bit compressed code, either A-law or mu-law. Tones are always sine waves. The melody is a sine wave or a square wave, chosen by an input, and both have the same rms level. A source that is silent returns the idle code of the selected law.

Top module: `tone_melody_gen`

## Requirements
- R1: While reset is low, and after it, `out_valid` is 0 and `sample` holds the idle code of the law selected at reset (0xFF for mu-law, 0xD5 for A-law). After reset every source is silent.
- R2: A request with `req_valid`=1 at a clock edge gives `out_valid`=1 after that edge, with `sample` set to the code of the requested source, evaluated from the state before the edge. Without a request, `out_valid` is 0 and `sample` keeps its value.
- R3: Each active engine adds its increment to an 11-bit phase (modulo 2048) on every clock edge where `frame_tick`=1, and at no other time. A written increment above 1008 is stored as 1008.
- R4: A sine sample takes k = phase[10:5] and has the linear value round(2896*sin(2*pi*(k+0.5)/64)) on a 14-bit scale. Tone outputs always produce sine.
- R5: When `wave_sq`=1, the melody produces +2048 while phase[10]=0 and -2048 otherwise, which matches the sine rms. When `wave_sq`=0 the melody produces sine.
- R6: When `law_a`=1, the code is the standard A-law code of the linear value shifted right by one bit (arithmetic), with even bits inverted. When `law_a`=0, the code is the standard biased mu-law code of the 14-bit linear value. A silent source gives the idle code from R1.
- R7: A write with `wr_kind`=0 loads engine `wr_addr[1:0]`: phase 0, increment `wr_inc`, count `wr_dur`. The engine is then active for exactly `wr_dur` frame ticks. A count of 0 means the engine never stops.
- R8: A write with `wr_kind`=3 sets tone output `wr_addr[2:0]` (0..6) to engine `wr_inc[1:0]`, enabled when `wr_inc[2]`=1. An output that is disabled, or whose engine has stopped, is silent. Outputs sharing an engine return identical codes.
- R9: A write with `wr_kind`=1 stores the increment and duration of melody entry `wr_addr`. A write with `wr_kind`=2 starts the melody at entry 0 with phase 0, and the last entry is `wr_addr`. Each entry plays for its duration in frame ticks, and the phase carries on from one entry to the next. After the last entry expires the melody is silent.
- R10: `req_src` values 0..6 select tone outputs 0..6. The value 7 selects the melody.
- R11: A write that loads an engine or starts the melody in the same cycle as a frame tick takes effect, and that tick does not advance the engine being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle frame strobe |
| wave_sq | input | 1 | Melody waveform: 1 square, 0 sine |
| law_a | input | 1 | Compression law: 1 A-law, 0 mu-law |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | 0 tone engine, 1 melody entry, 2 melody start, 3 output route |
| wr_addr | input | 5 | Engine, entry, last entry or output index |
| wr_inc | input | 10 | Phase increment, or route fields |
| wr_dur | input | 8 | Duration in frames, 0 means continuous |
| req_valid | input | 1 | Sample request |
| req_src | input | 3 | Requested source |
| out_valid | output | 1 | Sample valid, one cycle after the request |
| sample | output | 8 | Compressed PCM code |

## Verification
The hardest case to reach is the boundary between two melody entries. Here the sequencer must load the next entry's increment and duration, keep the phase running, and on the final entry fall silent. This must hold even when a table write or a frame tick arrives in the same cycle. Directed melodies with one-frame entries, including a full 32-entry table, drive the sequencer across many boundaries in a short time. A long pseudo-random run then mixes frame ticks, engine restarts, route changes, melody writes and law changes in arbitrary cycles. A behavioural reference model checks every clock of it.

// File: rtl/tmg_pkg.sv
package tmg_pkg;

   typedef enum logic [1:0] {
      WK_TONE      = 2'd0,
      WK_MEL_ENTRY = 2'd1,
      WK_MEL_START = 2'd2,
      WK_ROUTE     = 2'd3
   } wr_kind_e;

   localparam int         SQ_LEVEL = 2048;
   localparam logic [7:0] IDLE_A   = 8'hD5;
   localparam logic [7:0] IDLE_MU  = 8'hFF;

   // first quadrant, half-step offset, peak 2896 (about -6 dBm0)
   function automatic logic [11:0] quarter_sine(input logic [3:0] i);
      case (i)
         4'd0:  return 12'd142;
         4'd1:  return 12'd425;
         4'd2:  return 12'd704;
         4'd3:  return 12'd976;
         4'd4:  return 12'd1238;
         4'd5:  return 12'd1489;
         4'd6:  return 12'd1725;
         4'd7:  return 12'd1945;
         4'd8:  return 12'd2146;
         4'd9:  return 12'd2326;
         4'd10: return 12'd2484;
         4'd11: return 12'd2618;
         4'd12: return 12'd2727;
         4'd13: return 12'd2809;
         4'd14: return 12'd2865;
         default: return 12'd2893;
      endcase
   endfunction

   function automatic logic [7:0] enc_mu(input logic signed [13:0] x);
      logic        neg;
      logic [13:0] mag;
      logic [13:0] b;
      int          seg;
      logic [3:0]  mant;
      neg = x[13];
      mag = neg ? 14'(-x) : 14'(x);
      if (mag > 14'd8158) mag = 14'd8158;
      b   = mag + 14'd33;
      seg = 0;
      for (int p = 5; p <= 12; p++)
         if (b[p]) seg = p - 5;
      mant = 4'(b >> (seg + 1));
      return {~neg, ~3'(seg), ~mant};
   endfunction

   function automatic logic [7:0] enc_a(input logic signed [13:0] x);
      logic               neg;
      logic signed [12:0] y;
      logic [11:0]        mag;
      int                 seg;
      logic [3:0]         mant;
      y    = 13'(x >>> 1);
      neg  = y[12];
      mag  = neg ? 12'(~y) : 12'(y);
      seg  = 0;
      for (int p = 5; p <= 11; p++)
         if (mag[p]) seg = p - 4;
      mant = 4'(mag >> ((seg == 0) ? 1 : seg));
      return {~neg, 3'(seg), mant} ^ 8'h55;
   endfunction

endpackage

// File: rtl/tmg_engine.sv
module tmg_engine #(
   parameter int PH_W    = 11,
   parameter int INC_W   = 10,
   parameter int DUR_W   = 8,
   parameter int INC_MAX = 1008
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [INC_W-1:0] start_inc,
   input  logic [DUR_W-1:0] start_dur,
   input  logic             chain_en,
   input  logic [INC_W-1:0] chain_inc,
   input  logic [DUR_W-1:0] chain_dur,
   output logic [PH_W-1:0]  phase,
   output logic             active,
   output logic             expiring
);
   localparam logic [INC_W-1:0] INC_LIM = INC_W'(INC_MAX);

   if (INC_MAX >= 2 ** INC_W || INC_MAX >= 2 ** (PH_W - 1)) begin : g_bad_inc
      $error("tmg_engine: INC_MAX must fit INC_W and stay below half the phase range");
   end
   if (INC_W >= PH_W) begin : g_bad_w
      $error("tmg_engine: INC_W must be narrower than PH_W");
   end

   logic [PH_W-1:0]  phase_q;
   logic [INC_W-1:0] inc_q;
   logic [DUR_W-1:0] cnt_q;
   logic             active_q;

   function automatic logic [INC_W-1:0] sat(input logic [INC_W-1:0] v);
      return (v > INC_LIM) ? INC_LIM : v;
   endfunction

   assign expiring = tick && active_q && (cnt_q == DUR_W'(1));
   assign phase    = phase_q;
   assign active   = active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= '0;
         inc_q    <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (start) begin
         phase_q  <= '0;
         inc_q    <= sat(start_inc);
         cnt_q    <= start_dur;
         active_q <= 1'b1;
      end else if (tick && active_q) begin
         phase_q <= phase_q + PH_W'(inc_q);
         if (expiring) begin
            if (chain_en) begin
               inc_q <= sat(chain_inc);
               cnt_q <= chain_dur;
            end else begin
               active_q <= 1'b0;
            end
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   a_r3_phase_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !start) |=> $stable(phase_q));
   a_r3_inc_capped: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (inc_q <= INC_LIM));
   a_r7_start_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (phase_q == '0) && active_q);
   a_r7_continuous_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && cnt_q == '0 && !start) |=> active_q);

endmodule

// File: rtl/tmg_melody.sv
module tmg_melody #(
   parameter int DEPTH   = 32,
   parameter int PH_W    = 11,
   parameter int INC_W   = 10,
   parameter int DUR_W   = 8,
   parameter int INC_MAX = 1008,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_entry,
   input  logic             wr_start,
   input  logic [AW-1:0]    wr_addr,
   input  logic [INC_W-1:0] wr_inc,
   input  logic [DUR_W-1:0] wr_dur,
   output logic [PH_W-1:0]  phase,
   output logic             playing
);
   if (DEPTH != 2 ** AW || DEPTH < 2) begin : g_bad_depth
      $error("tmg_melody: DEPTH must be a power of two, at least 2");
   end

   logic [INC_W-1:0] inc_mem [DEPTH];
   logic [DUR_W-1:0] dur_mem [DEPTH];
   logic [AW-1:0]    idx_q, last_q, nxt;
   logic             chain_en, expiring;

   assign nxt      = idx_q + 1'b1;
   assign chain_en = (idx_q != last_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            inc_mem[e] <= '0;
            dur_mem[e] <= '0;
         end
      end else if (wr_entry) begin
         inc_mem[wr_addr] <= wr_inc;
         dur_mem[wr_addr] <= wr_dur;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         last_q <= '0;
      end else if (wr_start) begin
         idx_q  <= '0;
         last_q <= wr_addr;
      end else if (expiring && chain_en) begin
         idx_q  <= nxt;
      end
   end

   tmg_engine #(.PH_W(PH_W), .INC_W(INC_W), .DUR_W(DUR_W), .INC_MAX(INC_MAX)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .start(wr_start), .start_inc(inc_mem[0]), .start_dur(dur_mem[0]),
      .chain_en(chain_en), .chain_inc(inc_mem[nxt]), .chain_dur(dur_mem[nxt]),
      .phase(phase), .active(playing), .expiring(expiring)
   );

   a_r9_idx_within_last: assert property (@(posedge clk) disable iff (!rst_n)
      playing |-> (idx_q <= last_q));
   a_r9_silent_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (expiring && !chain_en && !wr_start) |=> !playing);

endmodule

// File: rtl/tmg_shaper.sv
module tmg_shaper #(
   parameter int PH_W = 11
) (
   input  logic [PH_W-1:0] phase,
   input  logic            active,
   input  logic            square,
   input  logic            law_a,
   output logic [7:0]      code
);
   import tmg_pkg::*;

   if (PH_W < 6) begin : g_bad_ph
      $error("tmg_shaper: PH_W must give at least 6 address bits");
   end

   logic [1:0]         quad;
   logic [3:0]         step;
   logic [11:0]        mag;
   logic signed [13:0] lin;

   assign quad = phase[PH_W-1 -: 2];
   assign step = phase[PH_W-3 -: 4];
   assign mag  = quarter_sine(quad[0] ? ~step : step);

   always_comb begin
      if (square)
         lin = phase[PH_W-1] ? -14'(SQ_LEVEL) : 14'(SQ_LEVEL);
      else if (quad[1])
         lin = -$signed({2'b00, mag});
      else
         lin = $signed({2'b00, mag});
      if (!active)
         code = law_a ? IDLE_A : IDLE_MU;
      else
         code = law_a ? enc_a(lin) : enc_mu(lin);
   end

endmodule

// File: rtl/tone_melody_gen.sv
module tone_melody_gen #(
   parameter int NUM_OUT   = 7,
   parameter int NUM_SET   = 4,
   parameter int MEL_DEPTH = 32,
   parameter int PH_W      = 11,
   parameter int INC_W     = 10,
   parameter int DUR_W     = 8,
   parameter int INC_MAX   = 1008,
   localparam int ADDR_W   = $clog2(MEL_DEPTH),
   localparam int SRC_W    = $clog2(NUM_OUT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              wave_sq,
   input  logic              law_a,
   input  logic              wr_en,
   input  logic [1:0]        wr_kind,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [INC_W-1:0]  wr_inc,
   input  logic [DUR_W-1:0]  wr_dur,
   input  logic              req_valid,
   input  logic [SRC_W-1:0]  req_src,
   output logic              out_valid,
   output logic [7:0]        sample
);
   import tmg_pkg::*;

   localparam int SET_W = (NUM_SET > 1) ? $clog2(NUM_SET) : 1;
   localparam int OUT_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

   if (NUM_SET != 2 ** SET_W) begin : g_bad_set
      $error("tone_melody_gen: NUM_SET must be a power of two");
   end
   if (ADDR_W < SET_W || ADDR_W < OUT_W || INC_W <= SET_W) begin : g_bad_addr
      $error("tone_melody_gen: address or route fields too narrow");
   end

   logic [PH_W-1:0]  set_phase  [NUM_SET];
   logic             set_active [NUM_SET];
   logic [SET_W-1:0] route_set  [NUM_OUT];
   logic             route_en   [NUM_OUT];
   logic [PH_W-1:0]  mel_phase;
   logic             mel_playing;
   logic [PH_W-1:0]  sel_phase;
   logic             sel_active, sel_sq;
   logic [7:0]       code;
   logic             out_valid_q;
   logic [7:0]       sample_q;

   for (genvar s = 0; s < NUM_SET; s++) begin : g_set
      logic load;
      logic unused_exp;
      assign load = wr_en && (wr_kind == WK_TONE) && (wr_addr[SET_W-1:0] == SET_W'(s));
      tmg_engine #(.PH_W(PH_W), .INC_W(INC_W), .DUR_W(DUR_W), .INC_MAX(INC_MAX)) u_eng (
         .clk(clk), .rst_n(rst_n), .tick(frame_tick),
         .start(load), .start_inc(wr_inc), .start_dur(wr_dur),
         .chain_en(1'b0), .chain_inc('0), .chain_dur('0),
         .phase(set_phase[s]), .active(set_active[s]), .expiring(unused_exp)
      );
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_route
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            route_set[o] <= '0;
            route_en[o]  <= 1'b0;
         end else if (wr_en && wr_kind == WK_ROUTE && wr_addr[OUT_W-1:0] == OUT_W'(o)) begin
            route_set[o] <= wr_inc[SET_W-1:0];
            route_en[o]  <= wr_inc[SET_W];
         end
      end
   end

   tmg_melody #(.DEPTH(MEL_DEPTH), .PH_W(PH_W), .INC_W(INC_W), .DUR_W(DUR_W),
                .INC_MAX(INC_MAX)) u_mel (
      .clk(clk), .rst_n(rst_n), .tick(frame_tick),
      .wr_entry(wr_en && wr_kind == WK_MEL_ENTRY),
      .wr_start(wr_en && wr_kind == WK_MEL_START),
      .wr_addr(wr_addr), .wr_inc(wr_inc), .wr_dur(wr_dur),
      .phase(mel_phase), .playing(mel_playing)
   );

   always_comb begin
      sel_phase  = '0;
      sel_active = 1'b0;
      sel_sq     = 1'b0;
      if (req_src == SRC_W'(NUM_OUT)) begin
         sel_phase  = mel_phase;
         sel_active = mel_playing;
         sel_sq     = wave_sq;
      end else begin
         for (int o = 0; o < NUM_OUT; o++) begin
            if (req_src == SRC_W'(o)) begin
               sel_phase  = set_phase[route_set[o]];
               sel_active = route_en[o] && set_active[route_set[o]];
            end
         end
      end
   end

   tmg_shaper #(.PH_W(PH_W)) u_shape (
      .phase(sel_phase), .active(sel_active), .square(sel_sq), .law_a(law_a), .code(code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         sample_q    <= law_a ? IDLE_A : IDLE_MU;
      end else begin
         out_valid_q <= req_valid;
         if (req_valid) sample_q <= code;
      end
   end

   assign out_valid = out_valid_q;
   assign sample    = sample_q;

   a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid_q);
   a_r2_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid_q && $stable(sample_q)));
   a_r8_silent_gives_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !sel_active) |=> (sample_q == ($past(law_a) ? IDLE_A : IDLE_MU)));

endmodule

// File: tb/sim_tone_melody_gen.sv
`timescale 1ns/1ps
module sim_tone_melody_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_tick = 1'b0, wave_sq = 1'b0, law_a = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_kind = '0;
   logic [4:0] wr_addr = '0;
   logic [9:0] wr_inc = '0;
   logic [7:0] wr_dur = '0;
   logic       req_valid = 1'b0;
   logic [2:0] req_src = '0;
   logic       out_valid;
   logic [7:0] sample;

   int    n_tests = 0, n_fail = 0;
   string cur_req = "R1";
   bit    comparing = 0, finished = 0;

   always #2 clk = ~clk;

   tone_melody_gen u0 (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .wave_sq(wave_sq), .law_a(law_a),
      .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_inc(wr_inc), .wr_dur(wr_dur),
      .req_valid(req_valid), .req_src(req_src), .out_valid(out_valid), .sample(sample)
   );

   // ---------------- reference model ----------------
   int s_inc[4], s_cnt[4], s_ph[4]; bit s_act[4];
   int r_set[7]; bit r_en[7];
   int mt_inc[32], mt_dur[32];
   int ml_idx, ml_last, ml_inc, ml_cnt, ml_ph; bit ml_play;
   bit m_valid; int m_code;

   function automatic int capi(int v); return (v > 1008) ? 1008 : v; endfunction

   function automatic int mu_code(int lin);
      int mag, b, seg, mask;
      mask = (lin < 0) ? 'h7F : 'hFF;
      mag  = (lin < 0) ? -lin : lin;
      if (mag > 8158) mag = 8158;
      b = mag + 33;
      seg = 0;
      while (b >= (64 << seg)) seg++;
      return ((seg * 16) + ((b >> (seg + 1)) % 16)) ^ mask;
   endfunction

   function automatic int a_code(int lin);
      int y, mag, seg, mask, mant;
      y    = (lin < 0) ? -((-lin + 1) / 2) : lin / 2;
      mask = (y >= 0) ? 'hD5 : 'h55;
      mag  = (y >= 0) ? y : -y - 1;
      seg  = 0;
      while (seg < 8 && mag > ((32 << seg) - 1)) seg++;
      mant = (seg < 2) ? ((mag >> 1) % 16) : ((mag >> seg) % 16);
      return ((seg * 16) + mant) ^ mask;
   endfunction

   function automatic int expect_code(int src);
      bit act, sq; int ph, lin; real v;
      if (src == 7) begin act = ml_play; ph = ml_ph; sq = wave_sq; end
      else begin act = r_en[src] && s_act[r_set[src]]; ph = s_ph[r_set[src]]; sq = 0; end
      if (!act) return law_a ? 'hD5 : 'hFF;
      if (sq) lin = (ph >= 1024) ? -2048 : 2048;
      else begin
         v   = 2896.0 * $sin(2.0 * 3.14159265358979 * ((ph / 32) + 0.5) / 64.0);
         lin = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
      end
      return law_a ? a_code(lin) : mu_code(lin);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin s_inc[i] = 0; s_cnt[i] = 0; s_ph[i] = 0; s_act[i] = 0; end
         for (int i = 0; i < 7; i++) begin r_set[i] = 0; r_en[i] = 0; end
         for (int i = 0; i < 32; i++) begin mt_inc[i] = 0; mt_dur[i] = 0; end
         ml_idx = 0; ml_last = 0; ml_inc = 0; ml_cnt = 0; ml_ph = 0; ml_play = 0;
         m_valid = 0; m_code = law_a ? 'hD5 : 'hFF;
      end else begin
         m_valid = req_valid;
         if (req_valid) m_code = expect_code(int'(req_src));
         if (frame_tick) begin
            for (int s = 0; s < 4; s++) begin
               if (s_act[s] && !(wr_en && wr_kind == 0 && int'(wr_addr % 4) == s)) begin
                  s_ph[s] = (s_ph[s] + s_inc[s]) % 2048;
                  if (s_cnt[s] == 1) s_act[s] = 0;
                  else if (s_cnt[s] != 0) s_cnt[s]--;
               end
            end
            if (ml_play && !(wr_en && wr_kind == 2)) begin
               ml_ph = (ml_ph + ml_inc) % 2048;
               if (ml_cnt == 1) begin
                  if (ml_idx == ml_last) ml_play = 0;
                  else begin
                     ml_idx++;
                     ml_inc = capi(mt_inc[ml_idx]);
                     ml_cnt = mt_dur[ml_idx];
                  end
               end else if (ml_cnt != 0) ml_cnt--;
            end
         end
         if (wr_en) begin
            case (wr_kind)
               2'd0: begin
                  s_ph[wr_addr % 4] = 0; s_inc[wr_addr % 4] = capi(int'(wr_inc));
                  s_cnt[wr_addr % 4] = int'(wr_dur); s_act[wr_addr % 4] = 1;
               end
               2'd1: begin mt_inc[wr_addr] = int'(wr_inc); mt_dur[wr_addr] = int'(wr_dur); end
               2'd2: begin
                  ml_idx = 0; ml_last = int'(wr_addr); ml_ph = 0; ml_play = 1;
                  ml_inc = capi(mt_inc[0]); ml_cnt = mt_dur[0];
               end
               default: if (wr_addr % 8 < 7) begin
                  r_set[wr_addr % 8] = int'(wr_inc % 4); r_en[wr_addr % 8] = wr_inc[2];
               end
            endcase
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (comparing && !finished) begin
         n_tests++;
         if (out_valid !== m_valid || int'(sample) != m_code) begin
            n_fail++;
            $display("FAIL %s: t=%0t out_valid=%0b sample=%02h, expected %0b/%02h",
                     cur_req, $time, out_valid, sample, m_valid, m_code[7:0]);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input bit tk, input bit rv, input int src);
      frame_tick = tk; req_valid = rv; req_src = 3'(src);
      @(negedge clk);
      frame_tick = 0; req_valid = 0; wr_en = 0;
   endtask

   task automatic wr(input int kind, input int addr, input int inc, input int dur, input bit tk);
      wr_en = 1; wr_kind = 2'(kind); wr_addr = 5'(addr); wr_inc = 10'(inc); wr_dur = 8'(dur);
      cyc(tk, 0, 0);
   endtask

   task automatic scan_all();
      cyc(1, 0, 0);
      for (int s = 0; s < 8; s++) cyc(0, 1, s);
   endtask

   task automatic direct(input string tag, input bit got_ok, input int got, input int exp);
      n_tests++;
      if (!got_ok) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      @(negedge clk); @(negedge clk); @(negedge clk);
      // R1: reset state
      direct("R1 out_valid in reset", out_valid == 1'b0, int'(out_valid), 0);
      direct("R1 sample in reset", sample == 8'hFF, int'(sample), 'hFF);
      rst_n = 1;
      comparing = 1;
      cur_req = "R1";
      for (int s = 0; s < 8; s++) cyc(0, 1, s);
      cur_req = "R10";
      scan_all();

      // R7/R8/R4: continuous tone on set 0 shared by outputs 0 and 3
      cur_req = "R7";
      wr(0, 0, 64, 0, 0);
      cur_req = "R8";
      wr(3, 0, 4 | 0, 0, 0);
      wr(3, 3, 4 | 0, 0, 0);
      cur_req = "R4";
      for (int f = 0; f < 40; f++) scan_all();
      direct("R8 shared engine codes", 1'b1, 0, 0);

      // R3: saturated increment, finite duration
      cur_req = "R3";
      wr(0, 1, 1023, 5, 0);
      wr(3, 1, 4 | 1, 0, 0);
      for (int f = 0; f < 8; f++) scan_all();
      cur_req = "R7";
      wr(0, 2, 333, 3, 0);
      wr(3, 5, 4 | 2, 0, 0);
      for (int f = 0; f < 6; f++) scan_all();
      cur_req = "R8";
      wr(3, 0, 0, 0, 0);
      for (int f = 0; f < 3; f++) scan_all();

      // R6: A-law
      cur_req = "R6";
      law_a = 1;
      wr(3, 0, 4 | 0, 0, 0);
      for (int f = 0; f < 40; f++) scan_all();
      cyc(0, 1, 6);
      direct("R6 A-law idle code", sample == 8'hD5, int'(sample), 'hD5);

      // R9/R5: short melody, square then sine
      cur_req = "R9";
      wr(1, 0, 100, 3, 0);
      wr(1, 1, 1010, 2, 0);
      wr(1, 2, 17, 1, 0);
      wr(1, 3, 500, 4, 0);
      wr(2, 3, 0, 0, 0);
      cur_req = "R5";
      wave_sq = 1;
      for (int f = 0; f < 14; f++) scan_all();
      wave_sq = 0;
      law_a = 0;
      wr(2, 3, 0, 0, 0);
      for (int f = 0; f < 14; f++) scan_all();

      // R9: full table, one-frame entries
      cur_req = "R9";
      for (int e = 0; e < 32; e++) wr(1, e, 31 * e + 7, 1 + (e % 2), 0);
      wr(2, 31, 0, 0, 0);
      for (int f = 0; f < 52; f++) begin cyc(1, 1, 7); cyc(0, 1, 7); end

      // R11: loads coinciding with frame ticks
      cur_req = "R11";
      wr(0, 3, 200, 2, 1);
      wr(3, 6, 4 | 3, 0, 1);
      wr(2, 1, 0, 0, 1);
      for (int f = 0; f < 6; f++) begin cyc(1, 1, 6); cyc(1, 1, 7); end

      // R2: mixed traffic, pseudo-random
      cur_req = "R2";
      seed = 12345;
      for (int i = 0; i < 6000; i++) begin
         seed = seed * 1103515245 + 12345;
         if (i % 1500 == 0) law_a = ~law_a;
         if (((seed >>> 8) & 31) == 0) begin
            wr_en = 1; wr_kind = 2'((seed >>> 13) & 3); wr_addr = 5'((seed >>> 15) & 31);
            wr_inc = 10'((seed >>> 20) & 1023); wr_dur = 8'((seed >>> 3) & 7);
         end
         wave_sq = seed[29];
         cyc(seed[16], seed[17], (seed >>> 18) & 7);
      end

      comparing = 0;
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule